// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs the external memory cycles of a small 8-bit controller whose low address byte and data byte share one set of pins. A request carries a cycle kind, a 16-bit address and a write byte. The block then plays out a fixed waveform, measured in whole oscillator clocks. The waveform consists of an address latch pulse, the address on the shared byte, and one active-low strobe: program fetch, data read or data write. The block captures the incoming byte at a fixed clock of the fetch or read waveform. When the cycle ends it returns that byte together with a one-clock completion pulse.

All timing is counted from the start of the cycle. Clock 0 is the first clock with the latch enable high. The shared byte and the high address byte each have their own output-enable, so the block can share a board-level bus with other drivers. The block offers a new request slot in the last clock of every cycle. Requests can therefore follow one another with no idle clock between them.

Top module: `mbus_seq`

## Requirements
- R1: While reset is asserted, and once it is released: ale is low, psen_n/rd_n/wr_n are high, both output-enables are low and done is low. req_ready is high from the second clock after release. Asserting reset in the middle of a cycle returns the outputs to this state at once.
- R2: The latch enable is high for exactly clocks 0 and 1 of every cycle. When a request is presented during the final clock of a cycle, the next cycle's clock 0 follows immediately, one clock after the strobe has returned high.
- R3: The low address byte is driven on the shared byte (ad_oe high) in clocks 1 and 2 only. The high address byte is driven (ah_oe high) in every clock of a cycle.
- R4: In a fetch cycle, psen_n is low in clocks 3, 4 and 5, and the shared byte is not driven from clock 3 on. The cycle's final clock is 6.
- R5: A fetch captures ad_in at the clock edge that ends clock 5. The captured byte appears on rdata with done high in clock 6.
- R6: In a read cycle, rd_n is low in clocks 5 to 10, and the shared byte is not driven from clock 3 on. ad_in is captured at the edge ending clock 9. done is high in final clock 11, with the captured byte on rdata.
- R7: In a write cycle, wr_n is low in clocks 5 to 10. The write byte is driven on the shared byte in clocks 4 to 11, and done is high in final clock 11.
- R8: At most one of psen_n, rd_n and wr_n is low at any time. ad_oe is low whenever psen_n or rd_n is low.
- R9: A request (req_valid high) is taken only when req_ready is high. req_ready is high when the block is idle or in the final clock of a cycle. A request presented while busy has no effect. done lasts exactly one clock per cycle.
- R10: The req_kind encoding is 2'b00 fetch, 2'b01 read and 2'b10 write. Code 2'b11 runs a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request slot open this clock |
| req_kind | input | 2 | Cycle kind (see R10) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured by the last fetch or read |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Value driven on the shared address/data byte |
| ad_oe | output | 1 | Output-enable for ad_out |
| ad_in | input | 8 | Value seen on the shared address/data byte |
| ah_out | output | 8 | High address byte |
| ah_oe | output | 1 | Output-enable for ah_out |

## Verification
The assertions assume that req_valid is sampled only at clock edges, and that reset is held long enough for the internal synchronizer to clear. The strobe-width properties also assume that a strobe is not cut short by a reset while it is low. The bench drives every request and every ad_in change half a clock away from the active edge. It applies the mid-cycle reset only in a directed test that carries no strobe-width expectation. ad_in shows the expected byte only in the capture clock and its complement in all other clocks, so a capture one clock early or late is detected.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10,
    CYC_RDALT = 2'b11
  } cyc_kind_e;

  localparam int PH_W         = 4;
  localparam int ALE_CLKS     = 2;  // latch pulse length
  localparam int PSEN_CLKS    = 3;  // fetch strobe length
  localparam int STB_CLKS     = 6;  // read/write strobe length
  localparam int RD_SMP_CLKS  = 5;  // read capture after strobe falls

  localparam logic [PH_W-1:0] PH_ALE_END   = PH_W'(ALE_CLKS);
  localparam logic [PH_W-1:0] PH_ADR_ON    = PH_W'(ALE_CLKS - 1);
  localparam logic [PH_W-1:0] PH_ADR_LAST  = PH_W'(ALE_CLKS);
  localparam logic [PH_W-1:0] PH_PSEN_ON   = PH_W'(ALE_CLKS + 1);
  localparam logic [PH_W-1:0] PH_PSEN_END  = PH_W'(ALE_CLKS + 1 + PSEN_CLKS);
  localparam logic [PH_W-1:0] PH_STB_ON    = PH_W'(ALE_CLKS + 3);
  localparam logic [PH_W-1:0] PH_STB_END   = PH_W'(ALE_CLKS + 3 + STB_CLKS);
  localparam logic [PH_W-1:0] PH_WDAT_ON   = PH_W'(ALE_CLKS + 2);
  localparam logic [PH_W-1:0] PH_FETCH_SMP = PH_W'(ALE_CLKS + PSEN_CLKS);
  localparam logic [PH_W-1:0] PH_READ_SMP  = PH_W'(ALE_CLKS + 2 + RD_SMP_CLKS);
  localparam logic [PH_W-1:0] PH_FETCH_LST = PH_W'(ALE_CLKS + 1 + PSEN_CLKS);
  localparam logic [PH_W-1:0] PH_RW_LST    = PH_W'(ALE_CLKS + 3 + STB_CLKS);

endpackage

// File: rtl/mbus_phase_ctr.sv
module mbus_phase_ctr
  import mbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  cyc_kind_e       req_kind,
  output logic            active,
  output logic [PH_W-1:0] phase,
  output cyc_kind_e       kind,
  output logic            last,
  output logic            accept
);

  logic            active_d;
  logic [PH_W-1:0] phase_d;
  cyc_kind_e       kind_d;

  always_comb begin
    last   = active && (phase == ((kind == CYC_FETCH) ? PH_FETCH_LST : PH_RW_LST));
    accept = req_valid && (!active || last);
  end

  always_comb begin
    active_d = active;
    phase_d  = phase;
    kind_d   = kind;
    if (accept) begin
      active_d = 1'b1;
      phase_d  = '0;
      kind_d   = req_kind;
    end else if (last) begin
      active_d = 1'b0;
      phase_d  = '0;
    end else if (active) begin
      phase_d  = phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= '0;
      kind   <= CYC_FETCH;
    end else begin
      active <= active_d;
      phase  <= phase_d;
      kind   <= kind_d;
    end
  end

endmodule

// File: rtl/mbus_strobe_dec.sv
module mbus_strobe_dec
  import mbus_pkg::*;
(
  input  logic            active,
  input  logic [PH_W-1:0] phase,
  input  cyc_kind_e       kind,
  input  logic            last,
  output logic            ale,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic            addr_en,
  output logic            wdat_en,
  output logic            cap_en,
  output logic            done
);

  logic is_fetch, is_wr, is_rd, in_stb;

  always_comb begin
    is_fetch = (kind == CYC_FETCH);
    is_wr    = (kind == CYC_WRITE);
    is_rd    = !is_fetch && !is_wr;
    in_stb   = (phase >= PH_STB_ON) && (phase < PH_STB_END);

    ale     = active && (phase < PH_ALE_END);
    psen_n  = !(active && is_fetch && (phase >= PH_PSEN_ON) && (phase < PH_PSEN_END));
    rd_n    = !(active && is_rd && in_stb);
    wr_n    = !(active && is_wr && in_stb);
    addr_en = active && (phase >= PH_ADR_ON) && (phase <= PH_ADR_LAST);
    wdat_en = active && is_wr && (phase >= PH_WDAT_ON) && (phase <= PH_STB_END);
    cap_en  = active && ((is_fetch && (phase == PH_FETCH_SMP)) ||
                         (is_rd && (phase == PH_READ_SMP)));
    done    = last;
  end

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     active,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     addr_en,
  input  logic                     wdat_en,
  input  logic                     cap_en,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] ah_out,
  output logic                     ah_oe,
  output logic [DATA_W-1:0]        rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap_en) begin
      rdata <= ad_in;
    end
  end

  always_comb begin
    if (addr_en)      ad_out = addr_q[DATA_W-1:0];
    else if (wdat_en) ad_out = wdata_q;
    else              ad_out = '0;
    ad_oe  = addr_en || wdat_en;
    ah_out = addr_q[ADDR_W-1:DATA_W];
    ah_oe  = active;
  end

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] ah_out,
  output logic                     ah_oe
);

  logic            rst_meta, srst_n;
  logic            active, last, accept;
  logic [PH_W-1:0] phase;
  cyc_kind_e       kind;
  logic            addr_en, wdat_en, cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  mbus_phase_ctr u_ctr (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_kind  (cyc_kind_e'(req_kind)),
    .active    (active),
    .phase     (phase),
    .kind      (kind),
    .last      (last),
    .accept    (accept)
  );

  mbus_strobe_dec u_dec (
    .active  (active),
    .phase   (phase),
    .kind    (kind),
    .last    (last),
    .ale     (ale),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr_en (addr_en),
    .wdat_en (wdat_en),
    .cap_en  (cap_en),
    .done    (done)
  );

  mbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (srst_n),
    .accept    (accept),
    .active    (active),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .addr_en   (addr_en),
    .wdat_en   (wdat_en),
    .cap_en    (cap_en),
    .ad_in     (ad_in),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .ah_out    (ah_out),
    .ah_oe     (ah_oe),
    .rdata     (rdata)
  );

  assign req_ready = srst_n && (!active || last);

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic done
);

  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ($past(ale, 2) && !$past(ale, 3))); // R2

  AST_PSEN_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |-> (!$past(ale) && $past(ale, 2))); // R4

  AST_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (!$past(rd_n, 6) && $past(rd_n, 7))); // R6

  AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (!$past(wr_n, 6) && $past(wr_n, 7))); // R7

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1); // R8

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !ad_oe); // R8

  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !$rose(ale)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

endmodule

bind mbus_seq mbus_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ale       (ale),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .done      (done)
);

// File: tb/tb_mbus_seq.sv
module tb_mbus_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam int EW = 23;

  // {kind[1:0], addr[15:0], wdata[7:0], resp[7:0], chain}
  localparam logic [34:0] VECS [NVEC] = '{
    {2'b00, 16'h1234, 8'h00, 8'hA5, 1'b0},
    {2'b01, 16'hBEEF, 8'h00, 8'h3C, 1'b1},
    {2'b10, 16'h8001, 8'h5A, 8'h00, 1'b1},
    {2'b00, 16'h00FF, 8'h00, 8'h81, 1'b1},
    {2'b11, 16'h7F00, 8'h00, 8'hC3, 1'b0},
    {2'b10, 16'hFFFF, 8'h96, 8'h00, 1'b0}
  };

  logic       clk, rst_n;
  logic       req_valid, req_ready;
  logic [1:0] req_kind;
  logic [15:0] req_addr;
  logic [7:0] req_wdata, rdata, ad_out, ad_in, ah_out;
  logic       done, ale, psen_n, rd_n, wr_n, ad_oe, ah_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  mbus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ah_out(ah_out), .ah_oe(ah_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] expect_at(input logic [1:0] k, input int p,
                                               input logic [15:0] a, input logic [7:0] w);
    bit f, wr, rd, e_ale, e_psn, e_rdn, e_wrn, e_oe, e_done;
    logic [7:0] e_val;
    f  = (k == 2'b00);
    wr = (k == 2'b10);
    rd = !f && !wr;
    e_ale  = (p < 2);
    e_psn  = !(f && p >= 3 && p <= 5);
    e_rdn  = !(rd && p >= 5 && p <= 10);
    e_wrn  = !(wr && p >= 5 && p <= 10);
    e_oe   = (p == 1 || p == 2) || (wr && p >= 4 && p <= 11);
    e_val  = (p == 1 || p == 2) ? a[7:0] : (e_oe ? w : 8'h00);
    e_done = (p == (f ? 6 : 11));
    return {e_ale, e_psn, e_rdn, e_wrn, e_oe, e_val, 1'b1, a[15:8], e_done};
  endfunction

  function automatic logic [EW-1:0] observed();
    return {ale, psen_n, rd_n, wr_n, ad_oe, (ad_oe ? ad_out : 8'h00),
            ah_oe, (ah_oe ? ah_out : 8'h00), done};
  endfunction

  task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] w);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = w;
    @(negedge clk);
  endtask

  // Called at the negedge of clock 0 of an accepted cycle.
  task automatic run_body(input logic [1:0] k, input logic [15:0] a, input logic [7:0] w,
                          input logic [7:0] resp, input bit chain, input logic [1:0] nk,
                          input logic [15:0] na, input logic [7:0] nw);
    int last_p, smp;
    string tag, dtag;
    last_p = (k == 2'b00) ? 6 : 11;
    smp    = (k == 2'b00) ? 5 : 9;
    tag    = (k == 2'b00) ? "R2 R3 R4 R8" : (k == 2'b10) ? "R2 R3 R7 R8" : "R2 R3 R6 R8";
    dtag   = (k == 2'b00) ? "R5" : (k == 2'b11) ? "R10" : "R6";
    for (int p = 0; p <= last_p; p++) begin
      req_valid = 1'b0;
      check(observed() == expect_at(k, p, a, w), tag, 32'(observed()), 32'(expect_at(k, p, a, w)));
      ad_in = (p == smp) ? resp : ~resp;
      if (p == last_p) begin
        if (k != 2'b10) check(rdata == resp, dtag, 32'(rdata), 32'(resp));
        check(req_ready == 1'b1, "R9", 32'(req_ready), 32'd1);
        if (chain) begin
          req_valid = 1'b1; req_kind = nk; req_addr = na; req_wdata = nw;
        end
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    bit pending;
    logic [34:0] v, nv;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0; req_wdata = '0; ad_in = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check({ale, psen_n, rd_n, wr_n, ad_oe, ah_oe, done} == 7'b0111000, "R1",
          32'({ale, psen_n, rd_n, wr_n, ad_oe, ah_oe, done}), 32'h38);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(req_ready == 1'b1, "R1", 32'(req_ready), 32'd1);
    check({ale, psen_n, rd_n, wr_n, ad_oe, done} == 6'b011100, "R1",
          32'({ale, psen_n, rd_n, wr_n, ad_oe, done}), 32'h1C);

    // table walk, including back-to-back chains
    pending = 0;
    for (int i = 0; i < NVEC; i++) begin
      v  = VECS[i];
      nv = (i + 1 < NVEC) ? VECS[i+1] : '0;
      if (!pending) issue(v[34:33], v[32:17], v[16:9]);
      run_body(v[34:33], v[32:17], v[16:9], v[8:1], v[0] && (i + 1 < NVEC),
               nv[34:33], nv[32:17], nv[16:9]);
      pending = v[0] && (i + 1 < NVEC);
    end

    // R9: request while busy is ignored
    repeat (2) @(negedge clk);
    issue(2'b01, 16'h4444, 8'h00);
    req_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b10; req_addr = 16'h9999; req_wdata = 8'hEE;
    check(req_ready == 1'b0, "R9", 32'(req_ready), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int seen_wr = 0, seen_ale = 0;
      for (int c = 0; c < 14; c++) begin
        if (!wr_n) seen_wr++;
        if (c >= 9 && ale) seen_ale++;
        @(negedge clk);
      end
      check(seen_wr == 0, "R9", 32'(seen_wr), 32'd0);
      check(seen_ale == 0, "R9", 32'(seen_ale), 32'd0);
    end

    // R1: reset in the middle of a write cycle
    issue(2'b10, 16'h2468, 8'h77);
    req_valid = 1'b0;
    repeat (7) @(negedge clk);
    check(wr_n == 1'b0, "R7", 32'(wr_n), 32'd0);
    rst_n = 1'b0;
    #1;
    check({ale, wr_n, ad_oe, ah_oe, done} == 5'b01000, "R1",
          32'({ale, wr_n, ad_oe, ah_oe, done}), 32'h08);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({ale, wr_n, ad_oe, req_ready} == 4'b0101, "R1",
          32'({ale, wr_n, ad_oe, req_ready}), 32'h5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule